// File: doc/BRIEF.md
# Auto-Incrementing Register Access Window

This block gives a host a two-location doorway into a bank of peripheral registers. One location is a pointer register: the host writes into it a register index, a stepping-mode flag and two spare mode bits. The other location is a data port. Each read or write of the data port reaches the bank entry that the pointer selects.

With the stepping flag set, the pointer moves on by one after every data-port access. A message can then be moved in or out one byte at a time without rewriting the pointer. When a step would carry the pointer past the last entry, the pointer returns to index zero and the stepping flag clears itself. The two spare mode bits keep their values.

A small state machine owns the stepping flag. Its two states are ST_FIXED, in which the pointer holds still, and ST_STEP, in which the pointer advances. Three transitions connect them:

- ARM goes from ST_FIXED to ST_STEP on a pointer write with bit 5 high.
- DISARM goes from ST_STEP to ST_FIXED on a pointer write with bit 5 low.
- OVERFLOW goes from ST_STEP to ST_FIXED on a data access while the index is at its top value.

Every other case stays in the current state.

Top module: `aiw_access_window`

## Requirements
- R1: After reset the pointer register reads 0x00, `rdata` is 0x00, and every bank entry reads 0x00.
- R2: When `sel_data`=0 and `wr_en`=1 (without `rd_en`), the whole byte is stored in the pointer register on that clock edge. When `sel_data`=0 and `rd_en`=1 (without `wr_en`), `rdata` shows the pointer register from the following cycle.
- R3: When `sel_data`=1 and `wr_en`=1 (without `rd_en`), `wdata` is stored into the bank entry whose index is pointer bits [4:0].
- R4: When `sel_data`=1 and `rd_en`=1 (without `wr_en`), `rdata` shows the selected bank entry from the cycle after the access.
- R5: While pointer bit 5 (stepping flag) is 1, each data-port read or write adds one to pointer bits [4:0]. The add takes effect on the edge that completes the access.
- R6: While pointer bit 5 is 0, data-port accesses leave the pointer unchanged, so repeated accesses reach the same entry. In idle cycles, `rdata` and the pointer register hold.
- R7: A stepping data access at index 31 leaves the pointer register at {bits [7:6] unchanged, 6'b000000}. This clears the stepping flag and returns the index to 0.
- R8: Writing 0x2A into the pointer register selects entry 10 with stepping on, so subsequent data writes fill entries 10, 11, 12 and onward in order.
- R9: A cycle with `rd_en` and `wr_en` both high has no effect. The pointer register, the bank and `rdata` all keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_data | input | 1 | 0 selects the pointer register, 1 selects the data port |
| wr_en | input | 1 | Write strobe for the selected location |
| rd_en | input | 1 | Read strobe for the selected location |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered on the edge that completes a read |

## Verification
A wrong pointer or a wrong stepping state shows at the ports as soon as the host reads. A data read returns the wrong entry one cycle after the access, and a pointer read exposes the bad index or flag directly. A missed overflow clear is the slowest fault to surface: it appears only as a pointer readback that is not 0xC0-style, or as a data read that lands on an unexpected entry after the wrap.

// File: rtl/aiw_pkg.sv
package aiw_pkg;
    localparam int DATA_W  = 8;
    localparam int PTR_W   = 5;
    localparam int DEPTH   = 1 << PTR_W;
    localparam int STEP_B  = PTR_W;
    localparam int MODE_W  = DATA_W - PTR_W - 1;

    typedef enum logic {
        ST_FIXED = 1'b0,
        ST_STEP  = 1'b1
    } aiw_state_e;
endpackage

// File: rtl/aiw_ptr_ctrl.sv
module aiw_ptr_ctrl
    import aiw_pkg::*;
#(
    parameter int P_DATA_W = DATA_W,
    parameter int P_PTR_W  = PTR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                addr_wr,
    input  logic [P_DATA_W-1:0] addr_wdata,
    input  logic                data_acc,
    output logic [P_DATA_W-1:0] addr_q,
    output logic [P_PTR_W-1:0]  ptr
);
    localparam int L_MODE_W = P_DATA_W - P_PTR_W - 1;
    localparam logic [P_PTR_W-1:0] PTR_TOP = '1;

    aiw_state_e state_q, state_d;
    logic [P_PTR_W-1:0]  ptr_q;
    logic [L_MODE_W-1:0] mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FIXED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FIXED: begin
                if (addr_wr && addr_wdata[P_PTR_W]) state_d = ST_STEP;
            end
            ST_STEP: begin
                if (addr_wr && !addr_wdata[P_PTR_W])  state_d = ST_FIXED;
                else if (!addr_wr && data_acc && ptr_q == PTR_TOP) state_d = ST_FIXED;
            end
            default: state_d = ST_FIXED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            mode_q <= '0;
        end else if (addr_wr) begin
            ptr_q  <= addr_wdata[P_PTR_W-1:0];
            mode_q <= addr_wdata[P_DATA_W-1:P_PTR_W+1];
        end else if (data_acc && state_q == ST_STEP) begin
            ptr_q  <= ptr_q + P_PTR_W'(1);
        end
    end

    always_comb begin
        addr_q = {mode_q, (state_q == ST_STEP), ptr_q};
        ptr    = ptr_q;
    end
endmodule

// File: rtl/aiw_regbank.sv
module aiw_regbank
    import aiw_pkg::*;
#(
    parameter int P_DATA_W = DATA_W,
    parameter int P_PTR_W  = PTR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [P_PTR_W-1:0]  idx,
    input  logic [P_DATA_W-1:0] din,
    output logic [P_DATA_W-1:0] dout
);
    localparam int L_DEPTH = 1 << P_PTR_W;

    logic [P_DATA_W-1:0] ent [L_DEPTH];

    for (genvar g = 0; g < L_DEPTH; g++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           ent[g] <= '0;
            else if (we && idx == P_PTR_W'(g))    ent[g] <= din;
        end
    end

    assign dout = ent[idx];
endmodule

// File: rtl/aiw_access_window.sv
module aiw_access_window
    import aiw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_data,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic              clash;
    logic              addr_wr, addr_rd, data_wr, data_rd, data_acc;
    logic [DATA_W-1:0] addr_q;
    logic [PTR_W-1:0]  ptr;
    logic [DATA_W-1:0] bank_out;
    logic [DATA_W-1:0] rdata_q;

    always_comb begin
        clash    = wr_en & rd_en;
        addr_wr  = !sel_data & wr_en & !clash;
        addr_rd  = !sel_data & rd_en & !clash;
        data_wr  =  sel_data & wr_en & !clash;
        data_rd  =  sel_data & rd_en & !clash;
        data_acc = data_wr | data_rd;
    end

    aiw_ptr_ctrl #(.P_DATA_W(DATA_W), .P_PTR_W(PTR_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_wr   (addr_wr),
        .addr_wdata(wdata),
        .data_acc  (data_acc),
        .addr_q    (addr_q),
        .ptr       (ptr)
    );

    aiw_regbank #(.P_DATA_W(DATA_W), .P_PTR_W(PTR_W)) u_bank (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (data_wr),
        .idx  (ptr),
        .din  (wdata),
        .dout (bank_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rdata_q <= '0;
        else if (data_rd) rdata_q <= bank_out;
        else if (addr_rd) rdata_q <= addr_q;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/aiw_access_window_chk.sv
module aiw_access_window_chk
    import aiw_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sel_data,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [DATA_W-1:0] addr_q
);
    localparam logic [PTR_W-1:0] TOP = '1;

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !rd_en) |=> ($stable(addr_q) && $stable(rdata)));

    assert_clash_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en) |=> ($stable(addr_q) && $stable(rdata)));

    assert_ptr_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_data && wr_en && !rd_en) |=> (addr_q == $past(wdata)));

    assert_fixed_ptr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_data && (wr_en ^ rd_en) && !addr_q[STEP_B]) |=> $stable(addr_q));

    assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_data && (wr_en ^ rd_en) && addr_q[STEP_B] && addr_q[PTR_W-1:0] != TOP)
        |=> (addr_q == $past(addr_q) + DATA_W'(1)));

    assert_overflow_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_data && (wr_en ^ rd_en) && addr_q[STEP_B] && addr_q[PTR_W-1:0] == TOP)
        |=> (addr_q == {$past(addr_q[DATA_W-1:STEP_B+1]), (PTR_W+1)'(0)}));

    assert_ptr_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_data && rd_en && !wr_en) |=> (rdata == $past(addr_q)));
endmodule

bind aiw_access_window aiw_access_window_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_data(sel_data),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .wdata   (wdata),
    .rdata   (rdata),
    .addr_q  (addr_q)
);

// File: tb/aiw_access_window_tb.sv
module aiw_access_window_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_data = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    int m_addr;
    int m_rdata;
    int m_regs [32];

    always #10 clk = ~clk;

    aiw_access_window u_dut (
        .clk(clk), .rst_n(rst_n), .sel_data(sel_data),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic model_step(input bit s, input bit w, input bit r, input int d);
        int p;
        if (w && r) return;
        if (!s) begin
            if (w) m_addr = d & 8'hFF;
            if (r) m_rdata = m_addr;
        end else if (w || r) begin
            p = m_addr & 31;
            if (w) m_regs[p] = d & 8'hFF;
            if (r) m_rdata = m_regs[p];
            if ((m_addr & 8'h20) != 0) begin
                if (p == 31) m_addr = m_addr & 8'hC0;
                else         m_addr = m_addr + 1;
            end
        end
    endtask

    task automatic op(input bit s, input bit w, input bit r, input int d, input string req);
        sel_data = s; wr_en = w; rd_en = r; wdata = d[7:0];
        @(posedge clk);
        model_step(s, w, r, d);
        @(negedge clk);
        sel_data = 0; wr_en = 0; rd_en = 0;
        check(req, rdata, m_rdata);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        m_addr = 0; m_rdata = 0;
        for (int i = 0; i < 32; i++) m_regs[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 rdata", rdata, 0);
        op(0, 0, 1, 0, "R1 ptr");
        check("R1 ptr const", rdata, 8'h00);
        op(1, 0, 1, 0, "R1 bank");

        op(0, 1, 0, 8'h2A, "R8 ptr wr");
        op(1, 1, 0, 8'h11, "R8 fill");
        op(1, 1, 0, 8'h22, "R8 fill");
        op(1, 1, 0, 8'h33, "R3 fill");
        op(0, 0, 1, 0, "R5 ptr rd");
        check("R5 ptr after 3", rdata, 8'h2D);

        op(0, 1, 0, 8'h0A, "R2 ptr wr");
        op(1, 0, 1, 0, "R4 rd");
        check("R4 entry10", rdata, 8'h11);
        op(1, 0, 1, 0, "R6 rd again");
        check("R6 same entry", rdata, 8'h11);
        op(0, 0, 1, 0, "R6 ptr rd");
        check("R6 ptr held", rdata, 8'h0A);
        op(0, 0, 0, 0, "R6 idle");

        op(0, 1, 0, 8'h0B, "R2 ptr wr");
        op(1, 1, 0, 8'h44, "R6 wr");
        op(1, 1, 0, 8'h55, "R6 wr");
        op(1, 0, 1, 0, "R6 rd");
        check("R6 overwrite", rdata, 8'h55);
        op(0, 1, 0, 8'h0C, "R2 ptr wr");
        op(1, 0, 1, 0, "R3 rd");
        check("R3 entry12", rdata, 8'h33);

        op(0, 1, 0, 8'hFE, "R7 ptr wr");
        op(1, 1, 0, 8'hA0, "R7 wr30");
        op(1, 1, 0, 8'hA1, "R7 wr31");
        op(0, 0, 1, 0, "R7 ptr rd");
        check("R7 wrap value", rdata, 8'hC0);
        op(1, 0, 1, 0, "R7 rd entry0");
        op(0, 0, 1, 0, "R7 ptr rd");
        check("R7 stepping off", rdata, 8'hC0);

        op(0, 1, 0, 8'h3F, "R7 ptr wr");
        op(1, 0, 1, 0, "R7 rd31");
        check("R7 entry31", rdata, 8'hA1);
        op(0, 0, 1, 0, "R7 ptr rd");
        check("R7 read wrap", rdata, 8'h00);

        op(0, 1, 0, 8'h2A, "R8 ptr wr");
        op(1, 1, 1, 8'hEE, "R9 clash data");
        check("R9 rdata kept", rdata, 8'h00);
        op(0, 0, 1, 0, "R9 ptr rd");
        check("R9 ptr kept", rdata, 8'h2A);
        op(1, 0, 1, 0, "R9 rd");
        check("R9 entry kept", rdata, 8'h11);
        op(0, 1, 1, 8'h77, "R9 clash ptr");
        op(0, 0, 1, 0, "R9 ptr rd");
        check("R9 ptr unchanged", rdata, 8'h2B);
        op(1, 0, 1, 0, "R5 stream rd");
        check("R5 entry11", rdata, 8'h55);
        op(1, 0, 1, 0, "R5 stream rd");
        check("R5 entry12", rdata, 8'h33);

        op(0, 1, 0, 8'h20, "R5 ptr wr");
        for (int i = 0; i < 32; i++) op(1, 1, 0, i * 3 + 1, "R3 full fill");
        op(0, 0, 1, 0, "R7 ptr rd");
        check("R7 fill wrap", rdata, 8'h00);
        op(0, 1, 0, 8'h20, "R5 ptr wr");
        for (int i = 0; i < 32; i++) begin
            op(1, 0, 1, 0, "R4 full read");
            check("R4 full value", rdata, i * 3 + 1);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule